// File: doc/BRIEF.md
# Interleaved Hardware-Thread Issue Selector

This block decides, on every cycle, which of several hardware threads may send its next instruction into one shared in-order pipeline. Each thread reports whether its instruction buffer holds an instruction, whether a trap or interrupt is waiting, whether a structural resource it needs is busy, whether software has suspended it, and whether its next instruction is a load. From these inputs the block forms a ready set. It grants the ready thread that was served longest ago, so threads interleave cycle by cycle and a stalled thread costs no issue slots.

Loads get special handling. A thread that has just issued a load stays selectable for non-load work before the load's hit or miss result is known. A dependent instruction can then pick up the loaded data by bypass. When the late result reports a miss, that thread is taken out of the ready set until its miss return arrives. If the thread had already issued past the load, a one-cycle replay flag is raised for it. A shared budget limits the number of loads in flight. A thread may also hold only one unresolved load at a time.

Top module: `mt_thread_picker`

## Requirements
- R1: `sel_o` has at most one bit set, and `issue_vld_o` is high exactly when `sel_o` is non-zero. When no thread is ready, both are zero in the same cycle.
- R2: Bit i of `sel_o` stands for thread i. With all threads ready and issuing ALU work from reset, the grant sequence is thread 0, 1, 2, 3, and then the sequence repeats.
- R3: Among ready threads, the grant goes to the one granted least recently. With exactly two threads ready, the grant alternates between them.
- R4: The least-recently-served order changes only in cycles where an instruction issues. A cycle with nothing ready leaves the order as it was.
- R5: A thread is not ready in any cycle where its buffer-valid bit is low, its trap/interrupt bit is high, or its resource-conflict bit is high.
- R6: A thread whose suspend bit is high is never selected.
- R7: A thread whose next instruction is a load is held in two cases: the in-flight load count has reached `MAX_LD`, or the thread already has a load awaiting its hit/miss result. The count rises when a load issues. It falls by one for each hit result and by one for each miss return.
- R8: After a thread issues a load, the thread may be selected for a non-load instruction before the load's result arrives.
- R9: A miss result for thread t makes thread t not ready from the next cycle onward. Thread t stays not ready up to and including the cycle in which `mret_vld_i` names it. It is ready again in the following cycle.
- R10: A miss result for thread t raises `replay_o[t]` for exactly one cycle, the cycle after the result. This happens only if thread t issued between its load and that result, with the result cycle counted.
- R11: A hit result raises no replay and does not stop the thread from being selected.
- R12: While reset is asserted and after it is released, `sel_o`, `issue_vld_o` and `replay_o` are zero until a buffer-valid bit goes high. The service order restarts from thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ibuf_vld_i | input | NUM_THR | Per-thread instruction available |
| trap_pend_i | input | NUM_THR | Per-thread trap or interrupt waiting |
| rsrc_busy_i | input | NUM_THR | Per-thread structural resource conflict |
| susp_i | input | NUM_THR | Per-thread software suspend |
| nxt_load_i | input | NUM_THR | Per-thread next instruction is a load |
| ldres_vld_i | input | 1 | Late load hit/miss result valid |
| ldres_miss_i | input | 1 | Result is a miss (1) or a hit (0) |
| ldres_tid_i | input | TID_W | Thread the result belongs to |
| mret_vld_i | input | 1 | Miss data returned |
| mret_tid_i | input | TID_W | Thread whose miss returned |
| sel_o | output | NUM_THR | One-hot selected thread |
| issue_vld_o | output | 1 | An instruction issues this cycle |
| replay_o | output | NUM_THR | One-cycle replay request per thread |

## Verification
The bench builds the block with four threads and `MAX_LD` of 2. With these values, two loads fill the budget, so a run of a few cycles can show the state where every thread waits on a load and nothing issues. It can then show one slot being freed by a hit result. Four threads let the full rotation, two-thread alternation and the least-recently-served reordering after suspends and traps be predicted by hand. The speculative-reselect, miss, replay and miss-return sequence runs on one thread, so each step falls in a known cycle.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int unsigned DEF_NUM_THR = 4;
  localparam int unsigned DEF_MAX_LD  = 2;
endpackage

// File: rtl/mtp_rst_sync.sv
module mtp_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_s_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n_o = sync_q[1];
endmodule

// File: rtl/mtp_thr_status.sv
module mtp_thr_status #(
  parameter int unsigned TID_W = 2,
  parameter int unsigned MY_ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             ibuf_vld_i,
  input  logic             trap_pend_i,
  input  logic             rsrc_busy_i,
  input  logic             susp_i,
  input  logic             nxt_load_i,
  input  logic             ld_full_i,
  input  logic             granted_i,
  input  logic             ldres_vld_i,
  input  logic             ldres_miss_i,
  input  logic [TID_W-1:0] ldres_tid_i,
  input  logic             mret_vld_i,
  input  logic [TID_W-1:0] mret_tid_i,
  output logic             ready_o,
  output logic             replay_o
);
  logic unres_q, unres_d;
  logic spec_q, spec_d;
  logic miss_q, miss_d;
  logic rply_q, rply_d;
  logic res_me, ret_me, upd;

  assign res_me = ldres_vld_i && (ldres_tid_i == TID_W'(MY_ID));
  assign ret_me = mret_vld_i && (mret_tid_i == TID_W'(MY_ID));

  assign ready_o = ibuf_vld_i && !trap_pend_i && !rsrc_busy_i && !susp_i &&
                   !miss_q && !(nxt_load_i && (ld_full_i || unres_q));

  always_comb begin
    unres_d = unres_q;
    spec_d  = spec_q;
    miss_d  = miss_q;
    rply_d  = 1'b0;
    if (res_me) begin
      unres_d = 1'b0;
      spec_d  = 1'b0;
      rply_d  = ldres_miss_i && (spec_q || (granted_i && unres_q));
    end else begin
      if (granted_i && nxt_load_i) unres_d = 1'b1;
      if (granted_i && unres_q)    spec_d  = 1'b1;
    end
    if (res_me && ldres_miss_i) miss_d = 1'b1;
    else if (ret_me)            miss_d = 1'b0;
  end

  assign upd = granted_i || res_me || ret_me || rply_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      unres_q <= 1'b0;
      spec_q  <= 1'b0;
      miss_q  <= 1'b0;
      rply_q  <= 1'b0;
    end else if (upd) begin
      unres_q <= unres_d;
      spec_q  <= spec_d;
      miss_q  <= miss_d;
      rply_q  <= rply_d;
    end
  end

  assign replay_o = rply_q;
endmodule

// File: rtl/mtp_ld_budget.sv
module mtp_ld_budget #(
  parameter int unsigned MAX_LD = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ld_issue_i,
  input  logic hit_i,
  input  logic ret_i,
  output logic full_o
);
  localparam int unsigned CNT_W = $clog2(MAX_LD + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    int tmp;
    tmp = int'(cnt_q);
    if (ld_issue_i) tmp = tmp + 1;
    if (hit_i)      tmp = tmp - 1;
    if (ret_i)      tmp = tmp - 1;
    if (tmp < 0)    tmp = 0;
    cnt_d = CNT_W'(tmp);
  end

  assign cnt_en = ld_issue_i || hit_i || ret_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q >= CNT_W'(MAX_LD));
endmodule

// File: rtl/mtp_lru_pick.sv
module mtp_lru_pick #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned TID_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic [NUM_THR-1:0] ready_i,
  output logic [NUM_THR-1:0] grant_o,
  output logic               found_o
);
  logic [TID_W-1:0] order_q [NUM_THR];
  logic [TID_W-1:0] order_d [NUM_THR];
  logic [TID_W-1:0] pos;
  logic             found;

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int p = 0; p < NUM_THR; p++) begin
      if (!found && ready_i[order_q[p]]) begin
        found = 1'b1;
        pos   = TID_W'(p);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_THR - 1; k++) begin
      if (k < int'(pos)) order_d[k] = order_q[k];
      else               order_d[k] = order_q[k+1];
    end
    order_d[NUM_THR-1] = order_q[pos];
  end

  assign found_o = found;
  assign grant_o = found ? (NUM_THR'(1) << order_q[pos]) : '0;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int k = 0; k < NUM_THR; k++) order_q[k] <= TID_W'(k);
    end else if (found) begin
      for (int k = 0; k < NUM_THR; k++) order_q[k] <= order_d[k];
    end
  end
endmodule

// File: rtl/mt_thread_picker.sv
module mt_thread_picker #(
  parameter int unsigned NUM_THR = mtp_pkg::DEF_NUM_THR,
  parameter int unsigned MAX_LD  = mtp_pkg::DEF_MAX_LD,
  parameter int unsigned TID_W   = $clog2(NUM_THR)
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic [NUM_THR-1:0] ibuf_vld_i,
  input  logic [NUM_THR-1:0] trap_pend_i,
  input  logic [NUM_THR-1:0] rsrc_busy_i,
  input  logic [NUM_THR-1:0] susp_i,
  input  logic [NUM_THR-1:0] nxt_load_i,
  input  logic               ldres_vld_i,
  input  logic               ldres_miss_i,
  input  logic [TID_W-1:0]   ldres_tid_i,
  input  logic               mret_vld_i,
  input  logic [TID_W-1:0]   mret_tid_i,
  output logic [NUM_THR-1:0] sel_o,
  output logic               issue_vld_o,
  output logic [NUM_THR-1:0] replay_o
);
  logic               rst_s_n;
  logic [NUM_THR-1:0] ready;
  logic [NUM_THR-1:0] grant;
  logic               found;
  logic               ld_full;
  logic               ld_issue;

  mtp_rst_sync u_rst (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .rst_s_n_o (rst_s_n)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    mtp_thr_status #(.TID_W(TID_W), .MY_ID(t)) u_st (
      .clk_i        (clk_i),
      .rst_n_i      (rst_s_n),
      .ibuf_vld_i   (ibuf_vld_i[t]),
      .trap_pend_i  (trap_pend_i[t]),
      .rsrc_busy_i  (rsrc_busy_i[t]),
      .susp_i       (susp_i[t]),
      .nxt_load_i   (nxt_load_i[t]),
      .ld_full_i    (ld_full),
      .granted_i    (grant[t]),
      .ldres_vld_i  (ldres_vld_i),
      .ldres_miss_i (ldres_miss_i),
      .ldres_tid_i  (ldres_tid_i),
      .mret_vld_i   (mret_vld_i),
      .mret_tid_i   (mret_tid_i),
      .ready_o      (ready[t]),
      .replay_o     (replay_o[t])
    );
  end

  mtp_lru_pick #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_pick (
    .clk_i   (clk_i),
    .rst_n_i (rst_s_n),
    .ready_i (ready),
    .grant_o (grant),
    .found_o (found)
  );

  assign ld_issue = |(grant & nxt_load_i);

  mtp_ld_budget #(.MAX_LD(MAX_LD)) u_budget (
    .clk_i      (clk_i),
    .rst_n_i    (rst_s_n),
    .ld_issue_i (ld_issue),
    .hit_i      (ldres_vld_i && !ldres_miss_i),
    .ret_i      (mret_vld_i),
    .full_o     (ld_full)
  );

  assign sel_o       = grant;
  assign issue_vld_o = found;
endmodule

// File: rtl/mt_thread_picker_chk.sv
module mt_thread_picker_chk #(
  parameter int unsigned NUM_THR = 4
) (
  input logic               clk_i,
  input logic               rst_n_i,
  input logic [NUM_THR-1:0] sel_o,
  input logic               issue_vld_o,
  input logic [NUM_THR-1:0] replay_o,
  input logic [NUM_THR-1:0] susp_i,
  input logic [NUM_THR-1:0] trap_pend_i,
  input logic [NUM_THR-1:0] rsrc_busy_i,
  input logic [NUM_THR-1:0] nxt_load_i,
  input logic               ldres_vld_i,
  input logic               ldres_miss_i,
  input logic               ld_full
);
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(sel_o));                                              // R1
  AST_VLD_MATCHES_SEL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    issue_vld_o == (sel_o != '0));                                 // R1
  AST_BLOCKED_NOT_SEL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel_o & (trap_pend_i | rsrc_busy_i)) == '0);                  // R5
  AST_SUSP_NOT_SEL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel_o & susp_i) == '0);                                       // R6
  AST_LOAD_CAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_full |-> ((sel_o & nxt_load_i) == '0));                     // R7
  AST_REPLAY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (replay_o != '0) |-> $past(ldres_vld_i && ldres_miss_i));      // R10
  AST_REPLAY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(replay_o));                                           // R10
endmodule

bind mt_thread_picker mt_thread_picker_chk #(.NUM_THR(NUM_THR)) u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .sel_o        (sel_o),
  .issue_vld_o  (issue_vld_o),
  .replay_o     (replay_o),
  .susp_i       (susp_i),
  .trap_pend_i  (trap_pend_i),
  .rsrc_busy_i  (rsrc_busy_i),
  .nxt_load_i   (nxt_load_i),
  .ldres_vld_i  (ldres_vld_i),
  .ldres_miss_i (ldres_miss_i),
  .ld_full      (ld_full)
);

// File: tb/mt_thread_picker_bench.sv
module mt_thread_picker_bench;
  localparam int N  = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ibuf, trap, rsrc, susp, nld;
  logic          rv, rmiss, mv;
  logic [TW-1:0] rtid, mtid;
  logic [N-1:0]  sel, replay;
  logic          ivld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mt_thread_picker #(.NUM_THR(N), .MAX_LD(2)) u_mt_thread_picker (
    .clk_i(clk), .rst_n_i(rst_n), .ibuf_vld_i(ibuf), .trap_pend_i(trap),
    .rsrc_busy_i(rsrc), .susp_i(susp), .nxt_load_i(nld),
    .ldres_vld_i(rv), .ldres_miss_i(rmiss), .ldres_tid_i(rtid),
    .mret_vld_i(mv), .mret_tid_i(mtid),
    .sel_o(sel), .issue_vld_o(ivld), .replay_o(replay)
  );

  // {ibuf, trap, rsrc, susp, expected sel}
  localparam logic [19:0] VEC [18] = '{
    20'hF0001, 20'hF0002, 20'hF0004, 20'hF0008, 20'hF0001,
    20'h50004, 20'h50001, 20'h50004, 20'h50001,
    20'hF0028, 20'hF0024,
    20'hF1002, 20'hF0108,
    20'h00000, 20'hF0001,
    20'hFF000, 20'h80008, 20'hF0004
  };

  function automatic string vtag(int i);
    if (i < 5)       return "R2";
    else if (i < 9)  return "R3";
    else if (i < 11) return "R6";
    else if (i < 13) return "R5";
    else if (i < 15) return "R4";
    else if (i == 15) return "R5";
    else             return "R3";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ibuf = '0; trap = '0; rsrc = '0; susp = '0; nld = '0;
    rv = 1'b0; rmiss = 1'b0; rtid = '0; mv = 1'b0; mtid = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R12", "sel in reset", 32'(sel), 0);
    chk("R12", "issue in reset", 32'(ivld), 0);
    chk("R12", "replay in reset", 32'(replay), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "sel after reset", 32'(sel), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    do_reset();

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      {ibuf, trap, rsrc, susp} = VEC[i][19:4];
      #1;
      chk(vtag(i), $sformatf("vec %0d sel", i), 32'(sel), 32'(VEC[i][3:0]));
      chk("R1", $sformatf("vec %0d issue", i), 32'(ivld), 32'(VEC[i][3:0] != 0));
    end

    // R12: reset restarts service order at thread 0
    do_reset();
    @(negedge clk); ibuf = 4'hF; #1;
    chk("R12", "first grant after reset", 32'(sel), 1);
    do_reset();

    // Load on thread 0, speculative reselect, miss, replay, return
    @(negedge clk); ibuf = 4'h1; nld = 4'h1; #1;
    chk("R7", "load issues under budget", 32'(sel), 1);
    @(negedge clk); nld = 4'h0; #1;
    chk("R8", "reselect before result", 32'(sel), 1);
    @(negedge clk); ibuf = 4'h0; rv = 1'b1; rmiss = 1'b1; rtid = 2'd0; #1;
    chk("R10", "no replay in result cycle", 32'(replay), 0);
    @(negedge clk); rv = 1'b0; rmiss = 1'b0; ibuf = 4'h1; #1;
    chk("R10", "replay after miss", 32'(replay), 1);
    chk("R9", "held after miss", 32'(sel), 0);
    @(negedge clk); mv = 1'b1; mtid = 2'd0; #1;
    chk("R10", "replay lasts one cycle", 32'(replay), 0);
    chk("R9", "held in return cycle", 32'(sel), 0);
    @(negedge clk); mv = 1'b0; #1;
    chk("R9", "ready after return", 32'(sel), 1);

    // Hit result: no replay, no stall
    @(negedge clk); nld = 4'h1; #1;
    chk("R7", "load issues again", 32'(sel), 1);
    @(negedge clk); nld = 4'h0; rv = 1'b1; rmiss = 1'b0; rtid = 2'd0; #1;
    chk("R8", "reselect in hit cycle", 32'(sel), 1);
    @(negedge clk); rv = 1'b0; #1;
    chk("R11", "no replay on hit", 32'(replay), 0);
    chk("R11", "still selectable after hit", 32'(sel), 1);

    // Load budget
    do_reset();
    @(negedge clk); ibuf = 4'hF; nld = 4'hF; #1;
    chk("R7", "first load", 32'(sel), 1);
    @(negedge clk); #1;
    chk("R7", "second load", 32'(sel), 2);
    @(negedge clk); #1;
    chk("R7", "budget full holds loads", 32'(sel), 0);
    chk("R1", "no issue when none ready", 32'(ivld), 0);
    @(negedge clk); nld = 4'hB; #1;
    chk("R7", "non-load passes full budget", 32'(sel), 4);
    @(negedge clk); nld = 4'hF; rv = 1'b1; rmiss = 1'b0; rtid = 2'd0; #1;
    chk("R7", "count frees only next cycle", 32'(sel), 0);
    @(negedge clk); rv = 1'b0; #1;
    chk("R7", "freed slot used in LRU order", 32'(sel), 8);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule